// File: doc/BRIEF.md
# Packed Media Integer ALU

This block is a lane-parallel integer unit for audio and video kernels. It takes a 64-bit pair of source operands, plus a 64-bit accumulator operand, and treats them as independent lanes of 8, 16 or 32 bits. In each lane it computes one of five operations: a rounding average, an absolute difference, an absolute difference added into the accumulator, a minimum or a maximum. A single flag selects whether lane values are read as two's-complement or as plain magnitudes. The packed result returns one clock after the operation is presented.

Alongside the result the block gives a 4-bit condition field. This field describes how the lowest lane of the two sources compares, worked out from b minus a. It does not depend on which operand a min or max operation picked. The caller supplies operands and the accumulator, and it owns decode, register storage and any looping over longer vectors.

Top module: `media_lane_alu`

## Requirements
- R1: `result`, `cond` and `out_valid` are registered. `out_valid` equals `in_valid` delayed by one clock. `result` and `cond` are loaded only in a cycle where `in_valid` is 1, and they hold their values while it is 0.
- R2: While reset is asserted, and after it is released until the first valid operation, `out_valid`, `result` and `cond` are all zero.
- R3: Opcode 0 (average) gives, in each lane, (a + b + 1) >> 1 truncated to the lane width, worked out without losing the carry. When `is_signed` is 1 the shift is arithmetic, so the average of -1 and -2 is -1.
- R4: Opcode 1 (absolute difference) gives a - b when a > b and b - a otherwise, modulo the lane width. The comparison follows `is_signed`.
- R5: Opcode 2 (abs-accumulate) gives acc + |a - b| in each lane, modulo the lane width. A carry out of a lane never reaches the next lane.
- R6: Opcode 3 (min) gives a when a < b, else b. Opcode 4 (max) gives a when a > b, else b. When `is_signed` is 1, the top bit of each lane is its sign. When `is_signed` is 0, lanes are unsigned magnitudes.
- R7: `lane_sel` picks the lane width: 0 selects 8-bit lanes, 1 selects 16-bit lanes, and 2 or 3 select 32-bit lanes. Lane i covers bits [i*W +: W].
- R8: When `cmp_en` is 1, `cond` holds {LT, GT, EQ, SO} in bits [3:0], taken from the lowest lane of `src_a` and `src_b` at the selected width and signedness. LT means a < b, GT means a > b, EQ means a == b, and SO is always 0. Exactly one of LT, GT and EQ is set, whatever the opcode.
- R9: When `cmp_en` is 0, a valid operation loads `cond` with 0.
- R10: Opcodes 5, 6 and 7 load `result` with 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| in_valid | input | 1 | An operation is presented this cycle |
| op | input | 3 | Operation code (0 avg, 1 absdiff, 2 abs-accumulate, 3 min, 4 max) |
| lane_sel | input | 2 | Lane width select (0: 8, 1: 16, 2/3: 32) |
| is_signed | input | 1 | Read lanes as two's-complement |
| cmp_en | input | 1 | Produce the condition field |
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source operand |
| src_acc | input | 64 | Accumulator operand for abs-accumulate |
| out_valid | output | 1 | Result registered from the previous cycle's operation |
| result | output | 64 | Lane-packed result |
| cond | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
The cases that are hardest to reach from the ports are the ones where the signed and unsigned readings of the same bits disagree. Examples are 0x80 against 0x01, or the most negative 32-bit value against the most positive one. In these cases a sign-handling error still gives a believable number. The stimulus therefore drives those exact pairs with both settings of the signedness flag, and feeds the condition field with a min operation whose chosen value differs from the comparison outcome. Carry isolation is reached by filling every accumulator lane with all ones, so that every lane wraps at the same time.

// File: rtl/media_alu_pkg.sv
package media_alu_pkg;

  localparam int unsigned NUM_SIZES = 3;
  localparam int unsigned OP_W      = 3;

  localparam logic [OP_W-1:0] OP_AVG    = 3'd0;
  localparam logic [OP_W-1:0] OP_ABSD   = 3'd1;
  localparam logic [OP_W-1:0] OP_ABSACC = 3'd2;
  localparam logic [OP_W-1:0] OP_MIN    = 3'd3;
  localparam logic [OP_W-1:0] OP_MAX    = 3'd4;

  // Lane width for size index 0,1,2 -> 8,16,32
  function automatic int unsigned lane_width(int unsigned idx);
    return 8 << idx;
  endfunction

  // Map the lane select code to a size index (3 folds onto 32-bit lanes)
  function automatic logic [1:0] size_index(logic [1:0] sel);
    return (sel == 2'd3) ? 2'd2 : sel;
  endfunction

endpackage

// File: rtl/media_rst_sync.sv
module media_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_nxt;

  always_comb stage_nxt = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_nxt;
  end

  assign rst_q_n = stage_q[1];
endmodule

// File: rtl/media_lane_op.sv
module media_lane_op
  import media_alu_pkg::*;
#(
  parameter int unsigned LW = 8
) (
  input  logic [OP_W-1:0] op,
  input  logic            sgn,
  input  logic [LW-1:0]   a,
  input  logic [LW-1:0]   b,
  input  logic [LW-1:0]   acc,
  output logic [LW-1:0]   res
);
  logic [LW:0]   a_x;
  logic [LW:0]   b_x;
  logic [LW:0]   sum;
  logic          a_lt_b;
  logic          a_gt_b;
  logic [LW-1:0] d_ab;
  logic [LW-1:0] d_ba;
  logic [LW-1:0] absd;

  always_comb begin
    // one extra bit keeps the rounding carry
    a_x = {sgn & a[LW-1], a};
    b_x = {sgn & b[LW-1], b};
    sum = a_x + b_x + {{LW{1'b0}}, 1'b1};

    if (sgn) begin
      a_lt_b = $signed(a) < $signed(b);
      a_gt_b = $signed(a) > $signed(b);
    end else begin
      a_lt_b = a < b;
      a_gt_b = a > b;
    end

    d_ab = a - b;
    d_ba = b - a;
    absd = a_gt_b ? d_ab : d_ba;

    case (op)
      OP_AVG:    res = sum[LW:1];
      OP_ABSD:   res = absd;
      OP_ABSACC: res = acc + absd;
      OP_MIN:    res = a_lt_b ? a : b;
      OP_MAX:    res = a_gt_b ? a : b;
      default:   res = '0;
    endcase
  end
endmodule

// File: rtl/media_cond_gen.sv
module media_cond_gen
  import media_alu_pkg::*;
#(
  parameter int unsigned CMP_W = 32
) (
  input  logic [CMP_W-1:0] a,
  input  logic [CMP_W-1:0] b,
  input  logic [1:0]       lane_sel,
  input  logic             sgn,
  input  logic             cmp_en,
  output logic [3:0]       cond
);
  logic [NUM_SIZES-1:0] lt_w;
  logic [NUM_SIZES-1:0] gt_w;
  logic [NUM_SIZES-1:0] eq_w;

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_width
    localparam int unsigned LW = lane_width(g);
    logic [LW:0] diff;
    // b - a with one guard bit: its sign says b < a
    always_comb diff = {sgn & b[LW-1], b[LW-1:0]} - {sgn & a[LW-1], a[LW-1:0]};
    assign gt_w[g] = diff[LW];
    assign eq_w[g] = (diff == '0);
    assign lt_w[g] = ~diff[LW] & (diff != '0);
  end

  logic [1:0] idx;
  always_comb begin
    idx = size_index(lane_sel);
    if (cmp_en) cond = {lt_w[idx], gt_w[idx], eq_w[idx], 1'b0};
    else        cond = 4'b0000;
  end
endmodule

// File: rtl/media_lane_alu.sv
module media_lane_alu
  import media_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   op,
  input  logic [1:0]        lane_sel,
  input  logic              is_signed,
  input  logic              cmp_en,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [DATA_W-1:0] src_acc,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        cond
);
  localparam int unsigned CMP_W = lane_width(NUM_SIZES - 1);

  logic rst_q_n;

  media_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  logic [DATA_W-1:0] res_w [NUM_SIZES];

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    localparam int unsigned LW = lane_width(g);
    localparam int unsigned NL = DATA_W / LW;
    logic [DATA_W-1:0] res_g;
    for (genvar l = 0; l < NL; l++) begin : g_lane
      media_lane_op #(.LW(LW)) u_lane (
        .op  (op),
        .sgn (is_signed),
        .a   (src_a[l*LW +: LW]),
        .b   (src_b[l*LW +: LW]),
        .acc (src_acc[l*LW +: LW]),
        .res (res_g[l*LW +: LW])
      );
    end
    assign res_w[g] = res_g;
  end

  logic [3:0] cond_nxt;

  media_cond_gen #(.CMP_W(CMP_W)) u_cond (
    .a        (src_a[CMP_W-1:0]),
    .b        (src_b[CMP_W-1:0]),
    .lane_sel (lane_sel),
    .sgn      (is_signed),
    .cmp_en   (cmp_en),
    .cond     (cond_nxt)
  );

  logic [DATA_W-1:0] res_nxt;
  logic              vld_nxt;
  logic [DATA_W-1:0] result_q;
  logic [3:0]        cond_q;
  logic              valid_q;

  always_comb begin
    vld_nxt = in_valid;
    res_nxt = res_w[size_index(lane_sel)];
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      valid_q  <= 1'b0;
      result_q <= '0;
      cond_q   <= '0;
    end else begin
      valid_q <= vld_nxt;
      if (in_valid) begin
        result_q <= res_nxt;
        cond_q   <= cond_nxt;
      end
    end
  end

  assign out_valid = valid_q;
  assign result    = result_q;
  assign cond      = cond_q;
endmodule

// File: rtl/media_lane_alu_chk.sv
module media_lane_alu_chk
  import media_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              in_valid,
  input logic [OP_W-1:0]   op,
  input logic [1:0]        lane_sel,
  input logic              is_signed,
  input logic              cmp_en,
  input logic [DATA_W-1:0] src_a,
  input logic [DATA_W-1:0] src_b,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic [3:0]        cond
);
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid |=> out_valid);

  a_r1_valid_drops: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> !out_valid);

  a_r1_hold_outputs: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> ($stable(result) && $stable(cond)));

  a_r8_so_zero: assert property (@(posedge clk) disable iff (!rst_q_n)
    cond[0] == 1'b0);

  a_r8_one_flag: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && cmp_en) |=> ($countones(cond[3:1]) == 1));

  a_r9_cmp_off: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && !cmp_en) |=> (cond == 4'b0000));

  a_r10_bad_op: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && op > OP_MAX) |=> (result == '0));

  a_r6_min_bound: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && op == OP_MIN && lane_sel == 2'd0 && !is_signed) |=>
      (result[7:0] <= $past(src_a[7:0]) && result[7:0] <= $past(src_b[7:0])));
endmodule

bind media_lane_alu media_lane_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .in_valid  (in_valid),
  .op        (op),
  .lane_sel  (lane_sel),
  .is_signed (is_signed),
  .cmp_en    (cmp_en),
  .src_a     (src_a),
  .src_b     (src_b),
  .out_valid (out_valid),
  .result    (result),
  .cond      (cond)
);

// File: tb/sim_media_lane_alu.sv
module sim_media_lane_alu;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  op;
  logic [1:0]  lane_sel;
  logic        is_signed;
  logic        cmp_en;
  logic [63:0] src_a, src_b, src_acc;
  logic        out_valid;
  logic [63:0] result;
  logic [3:0]  cond;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  media_lane_alu u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .lane_sel(lane_sel),
    .is_signed(is_signed), .cmp_en(cmp_en), .src_a(src_a), .src_b(src_b),
    .src_acc(src_acc), .out_valid(out_valid), .result(result), .cond(cond)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [63:0] model_res(input logic [2:0] o, input logic [1:0] ls,
      input logic sg, input logic [63:0] a, input logic [63:0] b, input logic [63:0] c);
    int lw;
    logic [63:0] m, sb, r, x, y, z, xs, ys, v, ad;
    lw = (ls == 2'd0) ? 8 : (ls == 2'd1) ? 16 : 32;
    m  = (64'd1 << lw) - 64'd1;
    sb = sg ? (64'd1 << (lw - 1)) : 64'd0;
    r  = '0;
    for (int i = 0; i < 64 / lw; i++) begin
      x  = (a >> (i * lw)) & m;
      y  = (b >> (i * lw)) & m;
      z  = (c >> (i * lw)) & m;
      xs = x ^ sb;
      ys = y ^ sb;
      ad = ((xs > ys) ? (x - y) : (y - x)) & m;
      case (o)
        3'd0: v = (((xs + ys + 64'd1) >> 1) ^ sb) & m;
        3'd1: v = ad;
        3'd2: v = (z + ad) & m;
        3'd3: v = (xs < ys) ? x : y;
        3'd4: v = (xs > ys) ? x : y;
        default: v = '0;
      endcase
      r = r | (v << (i * lw));
    end
    return r;
  endfunction

  function automatic logic [3:0] model_cond(input logic [1:0] ls, input logic sg,
      input logic ce, input logic [63:0] a, input logic [63:0] b);
    int lw;
    logic [63:0] m, sb, xs, ys;
    lw = (ls == 2'd0) ? 8 : (ls == 2'd1) ? 16 : 32;
    m  = (64'd1 << lw) - 64'd1;
    sb = sg ? (64'd1 << (lw - 1)) : 64'd0;
    xs = (a & m) ^ sb;
    ys = (b & m) ^ sb;
    if (!ce) return 4'b0000;
    return {xs < ys, xs > ys, xs == ys, 1'b0};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Present one operation at a falling edge; it registers at the next rising edge,
  // and the outputs are sampled at the falling edge after that.
  task automatic run_op(input string tag, input logic [2:0] o, input logic [1:0] ls,
      input logic sg, input logic ce, input logic [63:0] a, input logic [63:0] b,
      input logic [63:0] c);
    @(negedge clk);
    in_valid = 1'b1; op = o; lane_sel = ls; is_signed = sg; cmp_en = ce;
    src_a = a; src_b = b; src_acc = c;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " R1 valid"}, {63'd0, out_valid}, 64'd1);
    check({tag, " result"}, result, model_res(o, ls, sg, a, b, c));
    check({tag, " cond"}, {60'd0, cond}, {60'd0, model_cond(ls, sg, ce, a, b)});
  endtask

  task automatic t_reset;
    check("R2 valid in reset", {63'd0, out_valid}, 64'd0);
    check("R2 result in reset", result, 64'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 valid after release", {63'd0, out_valid}, 64'd0);
    check("R2 result after release", result, 64'd0);
    check("R2 cond after release", {60'd0, cond}, 64'd0);
  endtask

  task automatic t_avg;
    run_op("R3 avg u8 round up", 3'd0, 2'd0, 1'b0, 1'b1, 64'h0000_0000_00FF_FF01,
           64'h0000_0000_00FF_0002, 64'd0);
    check("R3 avg 1,2 -> 2", {56'd0, result[7:0]}, 64'h02);
    check("R3 avg FF,FF keeps carry", {56'd0, result[23:16]}, 64'hFF);
    run_op("R3 avg s16", 3'd0, 2'd1, 1'b1, 1'b1, 64'h8000_7FFF_0005_FFFF,
           64'h8000_7FFF_FFF0_FFFE, 64'd0);
    check("R3 avg -1,-2 -> -1", {48'd0, result[15:0]}, 64'hFFFF);
    run_op("R3 avg u32", 3'd0, 2'd2, 1'b0, 1'b0, 64'hFFFF_FFFF_1234_5678,
           64'hFFFF_FFFF_8765_4321, 64'd0);
  endtask

  task automatic t_absd;
    run_op("R4 absd u8", 3'd1, 2'd0, 1'b0, 1'b1, 64'h10F0_0080_0103_FF00,
           64'hF010_8000_0301_00FF, 64'd0);
    run_op("R4 absd s32 extremes", 3'd1, 2'd2, 1'b1, 1'b1, 64'h7FFF_FFFF_8000_0000,
           64'h8000_0000_7FFF_FFFF, 64'd0);
    check("R4 absd s32 wraps", {32'd0, result[31:0]}, 64'hFFFF_FFFF);
  endtask

  task automatic t_absacc;
    run_op("R5 absacc u8 wrap", 3'd2, 2'd0, 1'b0, 1'b1, 64'h0505_0505_0505_0505,
           64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R5 no carry between lanes", result, 64'h0404_0404_0404_0404);
    run_op("R5 absacc s16", 3'd2, 2'd1, 1'b1, 1'b1, 64'h8000_0001_FFFF_7FFF,
           64'h0001_8000_0001_8000, 64'h0001_FFFF_1234_0000);
  endtask

  task automatic t_minmax;
    run_op("R6 min u8", 3'd3, 2'd0, 1'b0, 1'b1, 64'h80, 64'h01, 64'd0);
    check("R6 min u8 picks 01", {56'd0, result[7:0]}, 64'h01);
    run_op("R6 min s8", 3'd3, 2'd0, 1'b1, 1'b1, 64'h80, 64'h01, 64'd0);
    check("R6 min s8 picks 80", {56'd0, result[7:0]}, 64'h80);
    run_op("R6 max s8", 3'd4, 2'd0, 1'b1, 1'b1, 64'h7F80_0102, 64'h807F_0201, 64'd0);
    run_op("R6 max u16", 3'd4, 2'd1, 1'b0, 1'b1, 64'hFFFF_0000_8000_7FFF,
           64'h0001_FFFF_7FFF_8000, 64'd0);
  endtask

  task automatic t_lanes;
    logic [63:0] r32;
    run_op("R7 lane32", 3'd1, 2'd2, 1'b0, 1'b1, 64'h0100_0000_0001_0000,
           64'h00FF_FFFF_0000_FFFF, 64'd0);
    r32 = result;
    run_op("R7 lane sel 3", 3'd1, 2'd3, 1'b0, 1'b1, 64'h0100_0000_0001_0000,
           64'h00FF_FFFF_0000_FFFF, 64'd0);
    check("R7 sel 3 equals sel 2", result, r32);
    run_op("R7 lane16", 3'd1, 2'd1, 1'b0, 1'b1, 64'h0100_0000_0001_0000,
           64'h00FF_FFFF_0000_FFFF, 64'd0);
  endtask

  task automatic t_cond;
    run_op("R8 eq", 3'd0, 2'd0, 1'b0, 1'b1, 64'h55, 64'h55, 64'd0);
    check("R8 eq code", {60'd0, cond}, 64'h2);
    run_op("R8 min cond tracks inputs", 3'd3, 2'd0, 1'b0, 1'b1, 64'h03, 64'h09, 64'd0);
    check("R8 lt code on min", {60'd0, cond}, 64'h8);
    run_op("R8 signed gt", 3'd4, 2'd1, 1'b1, 1'b1, 64'h0001, 64'hFFFF, 64'd0);
    check("R8 gt code", {60'd0, cond}, 64'h4);
    run_op("R8 unsigned lt", 3'd4, 2'd1, 1'b0, 1'b1, 64'h0001, 64'hFFFF, 64'd0);
    run_op("R8 s32 lane0 only", 3'd1, 2'd2, 1'b1, 1'b1, 64'h0000_0000_8000_0000,
           64'hFFFF_FFFF_0000_0000, 64'd0);
  endtask

  task automatic t_cmp_off;
    run_op("R9 cmp off", 3'd3, 2'd0, 1'b0, 1'b0, 64'h01, 64'h02, 64'd0);
    check("R9 cond zero", {60'd0, cond}, 64'h0);
  endtask

  task automatic t_badop;
    for (int k = 5; k < 8; k++) begin
      run_op("R10 bad op", 3'(k), 2'd0, 1'b0, 1'b1, 64'h1234_5678_9ABC_DEF0,
             64'h0FED_CBA9_8765_4321, 64'hFFFF_0000_FFFF_0000);
      check("R10 zero", result, 64'd0);
    end
  endtask

  task automatic t_hold;
    logic [63:0] r0;
    logic [3:0]  c0;
    run_op("R1 load", 3'd0, 2'd0, 1'b0, 1'b1, 64'h0102_0304_0506_0708,
           64'h1122_3344_5566_7788, 64'd0);
    r0 = result; c0 = cond;
    op = 3'd4; src_a = 64'hFFFF_FFFF_FFFF_FFFF; src_b = 64'd0; cmp_en = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 valid low when idle", {63'd0, out_valid}, 64'd0);
    check("R1 result held", result, r0);
    check("R1 cond held", {60'd0, cond}, {60'd0, c0});
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op = '0; lane_sel = '0; is_signed = 1'b0;
    cmp_en = 1'b0; src_a = '0; src_b = '0; src_acc = '0;
    repeat (3) @(negedge clk);
    t_reset;
    t_avg;
    t_absd;
    t_absacc;
    t_minmax;
    t_lanes;
    t_cond;
    t_cmp_off;
    t_badop;
    t_hold;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule